// File: doc/BRIEF.md
# Cycle-Steal Transfer Request Sequencer

This block sits in front of the bus engine of a multi-channel DMA controller. It decides when each channel asks for a transfer and does nothing else. Each channel has a request line from a peripheral, an enable bit that selects cycle-steal operation, and a programmable repeat interval counted in system clocks. The block drives one single-cycle transfer strobe per channel toward the bus engine.

The request lines are first brought into the clock domain through a synchronizer. In cycle-steal operation, a channel reacts to the low-to-high transition of its request line, not to its level. It issues one strobe at once, then arms a repeat counter loaded with the channel's interval. Each time the counter runs out, one more strobe is issued and the counter reloads. This continues for as long as the request stays high. When the request drops, the counter is stopped and the channel goes quiet until the next rising edge. Address generation, the transfer itself and arbitration between channels are handled elsewhere.

Top module: `cs_req_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `xfer_stb` is low after that edge, and the synchronizer and repeat counters are cleared.
- R2: A channel whose `steal_en` bit is low never raises its `xfer_stb` bit, whatever its request line does.
- R3: With `steal_en` high, a low-to-high change of `req_in[c]` that is first sampled at clock edge k raises `xfer_stb[c]` for one cycle after edge k+2. This latency comes from two synchronizer stages plus the strobe register.
- R4: After that strobe, while the request stays high and the channel stays enabled, further strobes follow every P cycles. P is the 16-bit unsigned field `period[16*c +: 16]`.
- R5: Once `req_in[c]` has been sampled low at edge k, `xfer_stb[c]` is low after edge k+2 and stays low until a new rising edge has been seen.
- R6: A period field of 0 behaves as 1, giving a strobe on every cycle while the request is held.
- R7: Channels are independent. Each one's strobes depend only on its own request, enable and period.
- R8: A request held high gives no further edge-triggered strobe. A request that drops and rises again restarts its repeat interval from the new edge, and the old phase is discarded.
- R9: Clearing `steal_en[c]` cancels the repeat on the next edge. Setting it while the request is already high gives no strobe until a new rising edge of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 4 | Asynchronous per-channel transfer request lines |
| steal_en | input | 4 | Per-channel cycle-steal enable |
| period | input | 64 | Per-channel repeat interval, 16 bits per channel, channel c at bits 16*c+15 down to 16*c |
| xfer_stb | output | 4 | Per-channel single-cycle transfer request strobe |

## Verification
The stimulus starts with a long steady request, which separates the first edge-timed strobe from the periodic repeats that follow. A one-cycle dropout shows whether the interval phase restarts or carries over. A request raised while the channel is disabled, and later enabled with the request still high, shows whether the block reacts to level or to edge. Two channels with coprime intervals started together reveal any crosstalk between channels. A zero interval checks the every-cycle case. A long random run then toggles requests, enables and intervals mid-flight, and the result is compared every cycle against a behavioural model.

// File: rtl/cs_req_pkg.sv
package cs_req_pkg;

   typedef enum logic {
      TMR_IDLE  = 1'b0,
      TMR_ARMED = 1'b1
   } tmr_state_e;

   localparam int MIN_CHANNELS = 1;
   localparam int MIN_PERIOD_W = 1;

endpackage

// File: rtl/cs_req_sync.sv
module cs_req_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (WIDTH < 1) begin : g_bad_width
      $error("cs_req_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("cs_req_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_sync = d_async;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            stage_q <= '0;
         end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) begin
               stage_q[i] <= stage_q[i-1];
            end
         end
      end

      assign q_sync = stage_q[STAGES-1];
   end

endmodule

// File: rtl/cs_req_timer.sv
module cs_req_timer
   import cs_req_pkg::*;
#(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic                stop,
   input  logic [PERIOD_W-1:0] period,
   output logic                fire
);

   localparam logic [PERIOD_W-1:0] CNT_ONE = PERIOD_W'(1);

   tmr_state_e          state_q;
   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W-1:0] reload;

   // a zero interval is treated as the shortest one
   assign reload = (period == '0) ? CNT_ONE : period;
   assign fire   = (state_q == TMR_ARMED) && (cnt_q == CNT_ONE);

   always_ff @(posedge clk) begin
      if (rst || stop) begin
         state_q <= TMR_IDLE;
         cnt_q   <= '0;
      end else if (start) begin
         state_q <= TMR_ARMED;
         cnt_q   <= reload;
      end else if (state_q == TMR_ARMED) begin
         if (cnt_q == CNT_ONE) begin
            cnt_q <= reload;
         end else begin
            cnt_q <= cnt_q - CNT_ONE;
         end
      end
   end

   AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (rst)
      (state_q == TMR_ARMED) |-> (cnt_q != '0)); // R4

   AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (rst)
      stop |=> (state_q == TMR_IDLE)); // R5

   AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
      (start && !stop) |=> (state_q == TMR_ARMED)); // R4

endmodule

// File: rtl/cs_req_channel.sv
module cs_req_channel #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                lvl,
   input  logic                en,
   input  logic [PERIOD_W-1:0] period,
   output logic                strobe
);

   logic prev_q;
   logic rise;
   logic halt;
   logic fire;

   assign rise = en && lvl && !prev_q;
   assign halt = !lvl || !en;

   cs_req_timer #(
      .PERIOD_W (PERIOD_W)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .start  (rise),
      .stop   (halt),
      .period (period),
      .fire   (fire)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         strobe <= 1'b0;
      end else begin
         prev_q <= lvl;
         // an edge and an expiry together still give a single strobe
         strobe <= !halt && (rise || fire);
      end
   end

   AST_RISE_STROBES: assert property (@(posedge clk) disable iff (rst)
      rise |=> strobe); // R3

   AST_LOW_SILENT: assert property (@(posedge clk) disable iff (rst)
      !lvl |=> !strobe); // R5

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
      !en |=> !strobe); // R2

endmodule

// File: rtl/cs_req_seq.sv
module cs_req_seq #(
   parameter int NUM_CH      = 4,
   parameter int PERIOD_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_CH-1:0]            req_in,
   input  logic [NUM_CH-1:0]            steal_en,
   input  logic [NUM_CH*PERIOD_W-1:0]   period,
   output logic [NUM_CH-1:0]            xfer_stb
);

   import cs_req_pkg::*;

   localparam int PERIOD_BUS_W = NUM_CH * PERIOD_W;

   if (NUM_CH < MIN_CHANNELS) begin : g_bad_ch
      $error("cs_req_seq: NUM_CH must be at least 1");
   end
   if (PERIOD_W < MIN_PERIOD_W) begin : g_bad_pw
      $error("cs_req_seq: PERIOD_W must be at least 1");
   end
   if (PERIOD_BUS_W != $bits(period)) begin : g_bad_bus
      $error("cs_req_seq: period bus width mismatch");
   end

   logic [NUM_CH-1:0] req_lvl;

   cs_req_sync #(
      .WIDTH  (NUM_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (req_in),
      .q_sync  (req_lvl)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cs_req_channel #(
         .PERIOD_W (PERIOD_W)
      ) u_chan (
         .clk    (clk),
         .rst    (rst),
         .lvl    (req_lvl[c]),
         .en     (steal_en[c]),
         .period (period[c*PERIOD_W +: PERIOD_W]),
         .strobe (xfer_stb[c])
      );
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (xfer_stb == '0)); // R1

endmodule

// File: tb/cs_req_seq_bench.sv
`timescale 1ns/1ps
module cs_req_seq_bench;

   localparam int NCH = 4;
   localparam int PW  = 16;

   logic              clk = 1'b0;
   logic              rst;
   logic [NCH-1:0]    drq;
   logic [NCH-1:0]    en;
   logic [NCH*PW-1:0] per;
   logic [NCH-1:0]    stb;

   int checks   = 0;
   int failures = 0;

   always #2 clk = ~clk;

   cs_req_seq u_cs_req_seq (
      .clk      (clk),
      .rst      (rst),
      .req_in   (drq),
      .steal_en (en),
      .period   (per),
      .xfer_stb (stb)
   );

   // behavioural reference: delayed request history, remaining cycles to next strobe
   int hist [NCH][$];
   int seen_prev [NCH];
   int armed [NCH];
   int remain [NCH];
   int expect_stb [NCH];

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (rst) begin
            hist[c] = {0, 0};
            seen_prev[c] = 0;
            armed[c] = 0;
            remain[c] = 0;
            expect_stb[c] = 0;
         end else begin
            int lvl;
            int p;
            lvl = hist[c][0];
            p = int'(per[c*PW +: PW]);
            if (p == 0) p = 1;
            if (lvl == 0 || en[c] == 1'b0) begin
               armed[c] = 0;
               expect_stb[c] = 0;
            end else if (seen_prev[c] == 0) begin
               armed[c] = 1;
               remain[c] = p;
               expect_stb[c] = 1;
            end else if (armed[c] != 0) begin
               if (remain[c] == 1) begin
                  expect_stb[c] = 1;
                  remain[c] = p;
               end else begin
                  expect_stb[c] = 0;
                  remain[c] = remain[c] - 1;
               end
            end else begin
               expect_stb[c] = 0;
            end
            seen_prev[c] = lvl;
            void'(hist[c].pop_front());
            hist[c].push_back(int'(drq[c]));
         end
      end
   end

   task automatic report_summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
      end
   endtask

   // one cycle: wait for the falling edge, then compare all channels with the model
   task automatic step();
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         check($sformatf("R4 R7 model ch%0d", c), int'(stb[c]), expect_stb[c]);
      end
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic count_stb(input int ch, input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         step();
         cnt += int'(stb[ch]);
      end
   endtask

   task automatic set_period(input int ch, input int p);
      per[ch*PW +: PW] = PW'(p);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      report_summary();
      $finish;
   end

   initial begin
      int n;
      int n0;
      int n3;
      rst = 1'b1;
      drq = '0;
      en  = '0;
      per = '0;
      repeat (3) @(negedge clk);
      check("R1 reset quiet", int'(stb), 0);
      rst = 1'b0;
      steps(2);

      // R3 / R4: steady request on channel 0, interval 5
      en[0] = 1'b1;
      set_period(0, 5);
      drq[0] = 1'b1;
      steps(2);
      check("R3 no strobe before latency", int'(stb[0]), 0);
      step();
      check("R3 edge strobe", int'(stb[0]), 1);
      count_stb(0, 20, n);
      check("R4 repeats at interval 5", n, 4);

      // R5: drop cancels
      drq[0] = 1'b0;
      steps(2);
      count_stb(0, 30, n);
      check("R5 quiet after drop", n, 0);

      // R6: zero interval means every cycle
      en[1] = 1'b1;
      set_period(1, 0);
      drq[1] = 1'b1;
      steps(3);
      check("R6 first strobe", int'(stb[1]), 1);
      count_stb(1, 10, n);
      check("R6 strobe every cycle", n, 10);
      drq[1] = 1'b0;
      steps(4);

      // R2 / R9: disabled channel, then enabled with request already high
      set_period(2, 4);
      drq[2] = 1'b1;
      count_stb(2, 20, n);
      check("R2 disabled channel silent", n, 0);
      en[2] = 1'b1;
      count_stb(2, 20, n);
      check("R9 enable while high gives no strobe", n, 0);
      drq[2] = 1'b0;
      steps(3);
      drq[2] = 1'b1;
      steps(2);
      check("R3 re-edge latency", int'(stb[2]), 0);
      step();
      check("R3 re-edge strobe", int'(stb[2]), 1);
      drq[2] = 1'b0;
      steps(4);

      // R7: two channels with coprime intervals started together
      set_period(0, 3);
      en[3] = 1'b1;
      set_period(3, 7);
      drq[0] = 1'b1;
      drq[3] = 1'b1;
      steps(2);
      n0 = 0;
      n3 = 0;
      for (int i = 0; i < 21; i++) begin
         step();
         n0 += int'(stb[0]);
         n3 += int'(stb[3]);
      end
      check("R7 channel 0 count", n0, 7);
      check("R7 channel 3 count", n3, 3);

      // R8: one-cycle dropout restarts the phase
      drq[0] = 1'b0;
      step();
      drq[0] = 1'b1;
      steps(3);
      check("R8 new edge strobe", int'(stb[0]), 1);
      count_stb(0, 2, n);
      check("R8 old phase discarded", n, 0);
      step();
      check("R8 interval from new edge", int'(stb[0]), 1);

      // R9: clearing the enable cancels the repeat
      en[3] = 1'b0;
      count_stb(3, 15, n);
      check("R9 disable cancels repeat", n, 0);

      // random run with mid-flight changes
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 199) == 0) en = NCH'($urandom);
         if ($urandom_range(0, 99) == 0) begin
            set_period(int'($urandom_range(0, NCH-1)), int'($urandom_range(0, 6)));
         end
         for (int c = 0; c < NCH; c++) begin
            if ($urandom_range(0, 15) == 0) drq[c] = ~drq[c];
         end
         step();
      end

      // R1: reset in the middle of activity
      en  = '1;
      drq = '1;
      rst = 1'b1;
      steps(2);
      check("R1 mid-run reset quiet", int'(stb), 0);
      rst = 1'b0;
      steps(10);

      report_summary();
      $finish;
   end

endmodule